// File: doc/BRIEF.md
# Strided Two-Dimensional DMA Address Generator

This block produces the source and destination byte addresses for a memory-to-memory copy in which the data is organised as equal-sized chunks separated by equal gaps. One pass can gather chunks from a strided source region and scatter them into a strided destination region, or pack strided data densely, or spread dense data out. The transfer moves in beats of 1, 2 or 4 bytes, selected by a width code that applies to both sides.

Software programs a start address per side, the width code, the total number of beats, a chunk length in beats that both sides share, and a per-side hole value: the gap between chunks in beats, plus one. A per-side enable selects whether that side honours the gaps or simply walks linearly. A start pulse loads the configuration when the block is idle and the configuration is legal. After that, each cycle in which the data path asserts the advance input moves both addresses to the next beat and adds one to the completed-beat count. The block raises done one cycle after the final beat and stays idle until the next start. Bus protocol, data movement and descriptor handling belong to neighbouring logic.

Top module: `stride_addr_gen`

## Requirements
- R1: After reset the block is idle: busy, done and rejected are 0, the completed-beat count is 0, and both addresses are 0.
- R2: A start pulse while idle with a legal configuration makes busy 1 on the next cycle. In that cycle each address equals its start address, the completed-beat count is 0, and done and rejected are 0.
- R3: Width codes 0, 1 and 2 mean 1-, 2- and 4-byte beats. On a side whose skip enable is 0, each accepted beat adds (1 << width code) bytes to the address.
- R4: On a side whose skip enable is 1, the beat that completes a chunk (the chunk length in beats is the shared boundary value) adds hole × (1 << width code) bytes instead. Every other beat adds (1 << width code). A hole of 1 therefore makes chunks contiguous.
- R5: Source and destination each have their own start address, hole value and skip enable, and they share the boundary and width code. A setting on one side never changes the other side's address sequence.
- R6: The completed-beat count rises by one on every accepted beat. In the cycle after the beat that brings the count to the programmed total, done is 1 and busy is 0. Done then holds until the next accepted start.
- R7: A start pulse while idle is refused if any of these holds: the total is 0; the total exceeds the largest count field value, 2^CNT_W − 1; the width code is 3; or a side has skip enabled with a boundary of 0 or a hole of 0. When refused, rejected becomes 1 on the next cycle, the block stays idle, and the addresses, count and done keep their values.
- R8: A start pulse while busy is ignored. The addresses, count and busy state continue as if it had not occurred.
- R9: An advance input while idle is ignored. The addresses and the completed-beat count do not change.
- R10: A total of exactly 2^CNT_W − 1 beats is accepted and runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load the configuration and begin, if idle |
| src_base | input | ADDR_W | Source start byte address |
| dst_base | input | ADDR_W | Destination start byte address |
| width_code | input | 2 | Beat size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| total_beats | input | CNT_W+1 | Total beats to transfer |
| boundary | input | BND_W | Chunk length in beats, shared by both sides |
| src_hole | input | HOLE_W | Source gap in beats plus one |
| dst_hole | input | HOLE_W | Destination gap in beats plus one |
| src_skip_en | input | 1 | Source honours the gaps |
| dst_skip_en | input | 1 | Destination honours the gaps |
| beat | input | 1 | One beat accepted this cycle |
| src_addr | output | ADDR_W | Current source byte address |
| dst_addr | output | ADDR_W | Current destination byte address |
| beats_done | output | CNT_W | Completed source beats |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| rejected | output | 1 | Last start was refused |

## Verification
The chunk-position counter is state that the ports do not show directly. A wrong value there appears as a hole jump in the wrong beat on a side that has skip enabled. On the next cycle that address is off by (hole − 1) beats and stays off for the rest of the transfer. A fault in the beat counter or the end detection shows up in the cycle after the final beat: done or busy is wrong there, or the count runs past the total. The bench therefore compares both addresses before every beat against a closed-form formula, over sweeps of width, boundary, both holes and all four skip combinations.

// File: rtl/stride_pkg.sv
// Shared definitions for the strided address generator.
// Assumes beat sizes are powers of two selected by a 2-bit code.
package stride_pkg;
    typedef enum logic [1:0] {
        BEAT_1B = 2'd0,
        BEAT_2B = 2'd1,
        BEAT_4B = 2'd2
    } beat_size_e;

    // Largest legal width code.
    localparam logic [1:0] WIDTH_CODE_MAX = BEAT_4B;
endpackage

// File: rtl/stride_cfg_check.sv
// Combinational legality check for a requested transfer.
// Assumes inputs are stable in the cycle the start pulse is seen.
module stride_cfg_check #(
    parameter int CNT_W  = 12,
    parameter int BND_W  = 16,
    parameter int HOLE_W = 16
) (
    input  logic [CNT_W:0]    total_req,
    input  logic [1:0]        wcode,
    input  logic [BND_W-1:0]  bnd,
    input  logic [HOLE_W-1:0] src_hole,
    input  logic [HOLE_W-1:0] dst_hole,
    input  logic              src_skip,
    input  logic              dst_skip,
    output logic              cfg_ok
);
    import stride_pkg::*;

    localparam logic [CNT_W:0] MAX_BEATS = {1'b0, {CNT_W{1'b1}}};

    logic bad_count;
    logic bad_width;
    logic bad_src;
    logic bad_dst;

    // Flag every illegal combination; the request passes only if none is set.
    always_comb begin
        bad_count = (total_req == '0) || (total_req > MAX_BEATS);
        bad_width = (wcode > WIDTH_CODE_MAX);
        bad_src   = src_skip && ((bnd == '0) || (src_hole == '0));
        bad_dst   = dst_skip && ((bnd == '0) || (dst_hole == '0));
        cfg_ok    = !(bad_count || bad_width || bad_src || bad_dst);
    end
endmodule

// File: rtl/stride_beat_track.sv
// Counts accepted beats, tracks the position inside the current chunk,
// and owns the busy/done state. Assumes total >= 1 and bnd >= 1 once loaded.
module stride_beat_track #(
    parameter int CNT_W = 12,
    parameter int BND_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             beat,
    input  logic [CNT_W-1:0] total,
    input  logic [BND_W-1:0] bnd,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] count,
    output logic             adv,
    output logic             at_edge
);
    logic [BND_W-1:0] pos;
    logic             last;

    // Decode the beat that is happening now.
    always_comb begin
        adv     = busy && beat;
        at_edge = (pos == bnd - BND_W'(1));
        last    = (count == total - CNT_W'(1));
    end

    // Update the beat count, the chunk position and the run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            count <= '0;
            pos   <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            done  <= 1'b0;
            count <= '0;
            pos   <= '0;
        end else if (adv) begin
            count <= count + CNT_W'(1);
            pos   <= at_edge ? '0 : pos + BND_W'(1);
            if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/stride_side.sv
// Address register for one side (source or destination).
// Steps by one beat, or by hole beats at a chunk edge when skip is enabled.
// Assumes HOLE_W <= ADDR_W.
module stride_side #(
    parameter int ADDR_W = 32,
    parameter int HOLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              adv,
    input  logic              at_edge,
    input  logic              skip_en,
    input  logic [HOLE_W-1:0] hole,
    input  logic [1:0]        wcode,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] inc;

    // Pick the byte increment for this beat.
    always_comb begin
        if (skip_en && at_edge)
            inc = ADDR_W'(hole) << wcode;
        else
            inc = ADDR_W'(1) << wcode;
    end

    // Load the start address or advance on an accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (adv)
            addr <= addr + inc;
    end
endmodule

// File: rtl/stride_addr_gen.sv
// Top of the strided two-dimensional address generator.
// Latches the configuration on an accepted start and drives two address
// sides from a shared beat/chunk tracker. Assumes one beat per cycle at most.
module stride_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12,
    parameter int BND_W  = 16,
    parameter int HOLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [1:0]        width_code,
    input  logic [CNT_W:0]    total_beats,
    input  logic [BND_W-1:0]  boundary,
    input  logic [HOLE_W-1:0] src_hole,
    input  logic [HOLE_W-1:0] dst_hole,
    input  logic              src_skip_en,
    input  logic              dst_skip_en,
    input  logic              beat,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  beats_done,
    output logic              busy,
    output logic              done,
    output logic              rejected
);
    localparam int N_SIDES = 2;

    logic              cfg_ok;
    logic              accept;
    logic              refuse;
    logic              adv;
    logic              at_edge;
    logic [1:0]        cfg_w;
    logic [BND_W-1:0]  cfg_bnd;
    logic [CNT_W-1:0]  cfg_total;
    logic              cfg_src_skip;
    logic              cfg_dst_skip;
    logic [HOLE_W-1:0] cfg_src_hole;
    logic [HOLE_W-1:0] cfg_dst_hole;

    logic [ADDR_W-1:0] base_a [N_SIDES];
    logic [HOLE_W-1:0] hole_a [N_SIDES];
    logic              skip_a [N_SIDES];
    logic [ADDR_W-1:0] addr_a [N_SIDES];

    stride_cfg_check #(.CNT_W(CNT_W), .BND_W(BND_W), .HOLE_W(HOLE_W)) u_check (
        .total_req (total_beats),
        .wcode     (width_code),
        .bnd       (boundary),
        .src_hole  (src_hole),
        .dst_hole  (dst_hole),
        .src_skip  (src_skip_en),
        .dst_skip  (dst_skip_en),
        .cfg_ok    (cfg_ok)
    );

    // Classify a start pulse seen while idle.
    always_comb begin
        accept = start && !busy && cfg_ok;
        refuse = start && !busy && !cfg_ok;
    end

    // Capture the transfer configuration when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_w        <= '0;
            cfg_bnd      <= '0;
            cfg_total    <= '0;
            cfg_src_skip <= 1'b0;
            cfg_dst_skip <= 1'b0;
            cfg_src_hole <= '0;
            cfg_dst_hole <= '0;
        end else if (accept) begin
            cfg_w        <= width_code;
            cfg_bnd      <= boundary;
            cfg_total    <= total_beats[CNT_W-1:0];
            cfg_src_skip <= src_skip_en;
            cfg_dst_skip <= dst_skip_en;
            cfg_src_hole <= src_hole;
            cfg_dst_hole <= dst_hole;
        end
    end

    // Remember whether the most recent idle start was refused.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rejected <= 1'b0;
        else if (accept)
            rejected <= 1'b0;
        else if (refuse)
            rejected <= 1'b1;
    end

    stride_beat_track #(.CNT_W(CNT_W), .BND_W(BND_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .beat    (beat),
        .total   (cfg_total),
        .bnd     (cfg_bnd),
        .busy    (busy),
        .done    (done),
        .count   (beats_done),
        .adv     (adv),
        .at_edge (at_edge)
    );

    // Gather per-side settings into arrays for the side generator.
    always_comb begin
        base_a[0] = src_base;
        base_a[1] = dst_base;
        hole_a[0] = cfg_src_hole;
        hole_a[1] = cfg_dst_hole;
        skip_a[0] = cfg_src_skip;
        skip_a[1] = cfg_dst_skip;
    end

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        stride_side #(.ADDR_W(ADDR_W), .HOLE_W(HOLE_W)) u_side (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (accept),
            .base    (base_a[s]),
            .adv     (adv),
            .at_edge (at_edge),
            .skip_en (skip_a[s]),
            .hole    (hole_a[s]),
            .wcode   (cfg_w),
            .addr    (addr_a[s])
        );
    end

    assign src_addr = addr_a[0];
    assign dst_addr = addr_a[1];
endmodule

// File: rtl/stride_addr_gen_chk.sv
// Property checker for the strided address generator, bound to the top.
module stride_addr_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              beat,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [CNT_W-1:0]  beats_done,
    input logic              busy,
    input logic              done,
    input logic              rejected,
    input logic [CNT_W-1:0]  cfg_total,
    input logic [1:0]        cfg_w,
    input logic              cfg_src_skip,
    input logic              cfg_dst_skip
);
    assert_load_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (beats_done == '0) && !done && !rejected);

    assert_src_linear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && beat && !cfg_src_skip |=>
            src_addr == $past(src_addr) + (ADDR_W'(1) << $past(cfg_w)));

    assert_dst_linear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && beat && !cfg_dst_skip |=>
            dst_addr == $past(dst_addr) + (ADDR_W'(1) << $past(cfg_w)));

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && beat && (beats_done == cfg_total - CNT_W'(1)) |=>
            done && !busy && (beats_done == $past(cfg_total)));

    assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (beats_done < cfg_total) && !done);

    assert_refused_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> !busy);

    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !beat |=>
            busy && $stable(src_addr) && $stable(dst_addr) && $stable(beats_done));

    assert_idle_beat_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start && beat |=>
            $stable(src_addr) && $stable(dst_addr) && $stable(beats_done));
endmodule

bind stride_addr_gen stride_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .beat         (beat),
    .src_addr     (src_addr),
    .dst_addr     (dst_addr),
    .beats_done   (beats_done),
    .busy         (busy),
    .done         (done),
    .rejected     (rejected),
    .cfg_total    (cfg_total),
    .cfg_w        (cfg_w),
    .cfg_src_skip (cfg_src_skip),
    .cfg_dst_skip (cfg_dst_skip)
);

// File: tb/stride_addr_gen_bench.sv
module stride_addr_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 12;
    localparam int BND_W  = 16;
    localparam int HOLE_W = 16;
    localparam int MAX_BEATS = (1 << CNT_W) - 1;
    localparam int WATCHDOG = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] src_base = '0;
    logic [ADDR_W-1:0] dst_base = '0;
    logic [1:0]        width_code = '0;
    logic [CNT_W:0]    total_beats = '0;
    logic [BND_W-1:0]  boundary = '0;
    logic [HOLE_W-1:0] src_hole = '0;
    logic [HOLE_W-1:0] dst_hole = '0;
    logic              src_skip_en = 1'b0;
    logic              dst_skip_en = 1'b0;
    logic              beat = 1'b0;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [CNT_W-1:0]  beats_done;
    logic              busy;
    logic              done;
    logic              rejected;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    stride_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BND_W(BND_W), .HOLE_W(HOLE_W)) u_stride_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
        .width_code(width_code), .total_beats(total_beats), .boundary(boundary),
        .src_hole(src_hole), .dst_hole(dst_hole), .src_skip_en(src_skip_en),
        .dst_skip_en(dst_skip_en), .beat(beat), .src_addr(src_addr), .dst_addr(dst_addr),
        .beats_done(beats_done), .busy(busy), .done(done), .rejected(rejected)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Closed-form address of beat k on one side.
    function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] base, input int k,
                                                   input int w, input int bnd, input int hole,
                                                   input bit skip);
        int units;
        units = skip ? (k + (k / bnd) * (hole - 1)) : k;
        return base + (ADDR_W'(units) << w);
    endfunction

    task automatic run_xfer(input logic [ADDR_W-1:0] sb, input logic [ADDR_W-1:0] db,
                            input int w, input int total, input int bnd,
                            input int sh, input int dh, input bit ss, input bit ds,
                            input bit gaps, input bit poke);
        string stag;
        stag = ss ? "R4 src" : "R3 src";
        @(negedge clk);
        src_base = sb; dst_base = db; width_code = 2'(w);
        total_beats = (CNT_W+1)'(total); boundary = BND_W'(bnd);
        src_hole = HOLE_W'(sh); dst_hole = HOLE_W'(dh);
        src_skip_en = ss; dst_skip_en = ds; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done && !rejected, "R2 load state", {busy, done, rejected}, 3'b100);
        check(beats_done == 0, "R2 count cleared", beats_done, 0);
        for (int k = 0; k < total; k++) begin
            if (gaps && (k % 3 == 2)) begin
                @(negedge clk);
                check(src_addr == exp_addr(sb, k, w, bnd, sh, ss), "R3 src stall", src_addr,
                      exp_addr(sb, k, w, bnd, sh, ss));
            end
            if (poke && k == 1) begin
                src_base = ~sb; dst_base = ~db; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check(busy && src_addr == exp_addr(sb, k, w, bnd, sh, ss), "R8 start while busy",
                      src_addr, exp_addr(sb, k, w, bnd, sh, ss));
            end
            check(src_addr == exp_addr(sb, k, w, bnd, sh, ss), stag, src_addr,
                  exp_addr(sb, k, w, bnd, sh, ss));
            check(dst_addr == exp_addr(db, k, w, bnd, dh, ds), "R5 dst", dst_addr,
                  exp_addr(db, k, w, bnd, dh, ds));
            check(beats_done == CNT_W'(k), "R6 count", beats_done, k);
            beat = 1'b1;
            @(negedge clk);
            beat = 1'b0;
        end
        check(done && !busy, "R6 done after last", {done, busy}, 2'b10);
        check(beats_done == CNT_W'(total), "R6 final count", beats_done, total);
        check(src_addr == exp_addr(sb, total, w, bnd, sh, ss), "R4 src end", src_addr,
              exp_addr(sb, total, w, bnd, sh, ss));
    endtask

    task automatic try_refused(input int w, input int total, input int bnd, input int sh,
                               input bit ss, input string tag);
        logic [ADDR_W-1:0] s0;
        logic [CNT_W-1:0]  c0;
        @(negedge clk);
        s0 = src_addr; c0 = beats_done;
        src_base = 32'h5555_0000; width_code = 2'(w); total_beats = (CNT_W+1)'(total);
        boundary = BND_W'(bnd); src_hole = HOLE_W'(sh); dst_hole = 1;
        src_skip_en = ss; dst_skip_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(rejected && !busy && done, tag, {rejected, busy, done}, 3'b101);
        check(src_addr == s0 && beats_done == c0, "R7 state kept", src_addr, s0);
    endtask

    initial begin
        logic [ADDR_W-1:0] s_keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !rejected, "R1 flags", {busy, done, rejected}, 0);
        check(beats_done == 0 && src_addr == 0 && dst_addr == 0, "R1 values", src_addr, 0);

        // Main sweep over width, boundary, holes and skip combinations.
        for (int w = 0; w < 3; w++)
            for (int b = 1; b <= 3; b++)
                for (int sh = 1; sh <= 3; sh++)
                    for (int dh = 1; dh <= 3; dh++)
                        for (int sk = 0; sk < 4; sk++)
                            run_xfer(32'h1000 + 32'(w * 64), 32'h8000 + 32'(b * 16), w, 2 * b + 1,
                                     b, sh, dh, sk[0], sk[1], (w == 1), (sk == 3 && b == 2));

        // Boundary longer than the transfer: no jumps taken.
        run_xfer(32'h2000, 32'h3000, 2, 3, 5, 4, 4, 1'b1, 1'b1, 1'b0, 1'b0);
        // Wide holes, address wrap near the top.
        run_xfer(32'hFFFF_FFF0, 32'h10, 1, 9, 2, 7, 1, 1'b1, 1'b1, 1'b1, 1'b0);

        // R9: advance while idle.
        s_keep = src_addr;
        beat = 1'b1;
        @(negedge clk);
        @(negedge clk);
        beat = 1'b0;
        check(src_addr == s_keep && beats_done == 9, "R9 idle beat", src_addr, s_keep);

        // R7 refusal cases.
        try_refused(0, 0, 2, 2, 1'b1, "R7 zero total");
        try_refused(0, MAX_BEATS + 1, 2, 2, 1'b0, "R7 too many beats");
        try_refused(3, 4, 2, 2, 1'b0, "R7 width code 3");
        try_refused(1, 4, 0, 2, 1'b1, "R7 zero boundary");
        try_refused(1, 4, 2, 0, 1'b1, "R7 zero hole");

        // R10: largest count.
        run_xfer(32'h4_0000, 32'h8_0000, 0, MAX_BEATS, 7, 2, 3, 1'b1, 1'b0, 1'b0, 1'b0);
        check(!rejected, "R10 max accepted", rejected, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule